// File: doc/BRIEF.md
# Scratch Load/Store Engine

This block is the memory-transfer unit of a wide-issue core. It moves 32-bit words between a word-addressed main memory and a scratch register file. Each cycle it can accept up to `N_LOAD` load slots and up to `N_STORE` store slots, all already decoded. A load slot can write an immediate, fetch one word, fetch a contiguous block of `VLEN` words, or gather one word through a pointer held in scratch into a chosen lane of a destination vector. A store slot writes either one word or a contiguous block of `VLEN` words into main memory.

Every read in a cycle sees the state from before that cycle. All scratch and memory writes commit together at the clock edge. When two writes in one cycle target the same location, the slot with the higher number wins. Both storage arrays live inside the block. One registered observation port lets neighbouring units (and the bench) read a scratch word.

Top module: `ldst_engine`

## Requirements
- R1: While `rst` is high, `obs_data` is cleared to 0. Otherwise `obs_data` shows scratch[`obs_addr`] as it was before the rising edge that loads `obs_data`, one cycle after the address is presented.
- R2: A load slot with opcode 2'b00 (immediate) writes its 32-bit `imm` into scratch[dst].
- R3: A load slot with opcode 2'b01 (word) writes mem[scratch[src]] into scratch[dst].
- R4: A load slot with opcode 2'b10 (block) writes mem[A+j] into scratch[dst+j] for j = 0..VLEN-1, where A = scratch[src].
- R5: A load slot with opcode 2'b11 (gather) takes lane k = imm[2:0]. It writes mem[scratch[src+k]] into scratch[dst+k] and leaves the other lanes of the destination unchanged.
- R6: A store slot with `st_vec`=0 writes scratch[src] into mem[scratch[aptr]].
- R7: A store slot with `st_vec`=1 writes scratch[src+j] into mem[A+j] for j = 0..VLEN-1, where A = scratch[aptr].
- R8: Every slot reads scratch and memory as they were before the cycle. A write issued in the same cycle is never visible to another slot of that cycle.
- R9: When several slots in one cycle write the same scratch or memory location, the higher-numbered slot's value is kept.
- R10: A slot whose enable bit is 0 changes nothing. Store slots never change scratch.
- R11: Addresses are 11 bits wide. The scratch index and the memory index are the address modulo the array depth, so block accesses wrap past the top of the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | N_LOAD | Per-slot load enable |
| ld_op | input | 2*N_LOAD | Per-slot load opcode (00 imm, 01 word, 10 block, 11 gather) |
| ld_dst | input | 11*N_LOAD | Per-slot scratch destination address |
| ld_src | input | 11*N_LOAD | Per-slot scratch address of the pointer or pointer table |
| ld_imm | input | 32*N_LOAD | Per-slot immediate; bits [2:0] select the lane for gather |
| st_en | input | N_STORE | Per-slot store enable |
| st_vec | input | N_STORE | 1 selects a block store, 0 a word store |
| st_aptr | input | 11*N_STORE | Scratch address holding the memory address |
| st_src | input | 11*N_STORE | Scratch address of the data to store |
| obs_addr | input | 11 | Scratch address to observe |
| obs_data | output | 32 | Registered scratch word at `obs_addr` |

## Verification
The hardest case to reach is a single cycle in which one slot rewrites a pointer or a data word while another slot uses the old value to fetch or store. A second hard case is two slots landing on one location. Neither can be seen directly at the ports, because the only window into memory is a later word load. The stimulus first builds known pointer and data words with immediate loads and stores. It then issues the conflicting slots together in one cycle, and reads each affected location back afterwards through a fresh word load and the observation port.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [1:0] {
    LD_IMM    = 2'b00,
    LD_WORD   = 2'b01,
    LD_BLOCK  = 2'b10,
    LD_GATHER = 2'b11
  } ld_op_e;
endpackage

// File: rtl/ldst_regfile.sv
// Word array with NRD combinational read ports and NWR write ports.
// Writes commit at the edge; a higher-numbered write port wins on a clash.
module ldst_regfile #(
  parameter int DEPTH = 256,
  parameter int AW    = 11,
  parameter int DW    = 32,
  parameter int NRD   = 1,
  parameter int NWR   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NRD*AW-1:0] rd_addr,
  output logic [NRD*DW-1:0] rd_data,
  input  logic [NWR-1:0]    wr_en,
  input  logic [NWR*AW-1:0] wr_addr,
  input  logic [NWR*DW-1:0] wr_data
);
  localparam int IW = $clog2(DEPTH);

  logic [DW-1:0] arr_q [DEPTH];

  // High address bits beyond the depth are dropped: indices wrap.
  logic unused_hi_bits;
  assign unused_hi_bits = &{1'b0, rd_addr, wr_addr};

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data[r*DW +: DW] = arr_q[rd_addr[r*AW +: IW]];
  end

  always_ff @(posedge clk) begin
    if (!rst) begin
      for (int w = 0; w < NWR; w++) begin
        if (wr_en[w]) arr_q[wr_addr[w*AW +: IW]] <= wr_data[w*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/ldst_load_slot.sv
// One load slot: forms read addresses and up to VLEN scratch write lanes.
module ldst_load_slot
  import ldst_pkg::*;
#(
  parameter int AW   = 11,
  parameter int DW   = 32,
  parameter int VLEN = 8
) (
  input  logic               en,
  input  logic [1:0]         op,
  input  logic [AW-1:0]      dst,
  input  logic [AW-1:0]      src,
  input  logic [DW-1:0]      imm,
  output logic [AW-1:0]      scr_raddr,
  input  logic [DW-1:0]      scr_rdata,
  output logic [VLEN*AW-1:0] mem_raddr,
  input  logic [VLEN*DW-1:0] mem_rdata,
  output logic [VLEN-1:0]    wr_en,
  output logic [VLEN*AW-1:0] wr_addr,
  output logic [VLEN*DW-1:0] wr_data
);
  localparam int LW = $clog2(VLEN);

  ld_op_e        opc;
  logic [AW-1:0] lane_off;
  logic [AW-1:0] base;
  logic          unused_ptr_hi;

  assign opc           = ld_op_e'(op);
  assign lane_off      = AW'(imm[LW-1:0]);
  assign scr_raddr     = (opc == LD_GATHER) ? src + lane_off : src;
  assign base          = scr_rdata[AW-1:0];
  assign unused_ptr_hi = &{1'b0, scr_rdata};

  for (genvar j = 0; j < VLEN; j++) begin : g_mra
    if (j == 0) begin : g_l0
      assign mem_raddr[0 +: AW] = base;
    end else begin : g_ln
      assign mem_raddr[j*AW +: AW] = (opc == LD_BLOCK) ? base + AW'(j) : base;
    end
  end

  always_comb begin
    wr_en   = '0;
    wr_addr = '0;
    wr_data = '0;
    unique case (opc)
      LD_IMM: begin
        wr_en[0]        = en;
        wr_addr[0 +: AW] = dst;
        wr_data[0 +: DW] = imm;
      end
      LD_WORD: begin
        wr_en[0]        = en;
        wr_addr[0 +: AW] = dst;
        wr_data[0 +: DW] = mem_rdata[0 +: DW];
      end
      LD_BLOCK: begin
        for (int j = 0; j < VLEN; j++) begin
          wr_en[j]           = en;
          wr_addr[j*AW +: AW] = dst + AW'(j);
          wr_data[j*DW +: DW] = mem_rdata[j*DW +: DW];
        end
      end
      LD_GATHER: begin
        wr_en[0]        = en;
        wr_addr[0 +: AW] = dst + lane_off;
        wr_data[0 +: DW] = mem_rdata[0 +: DW];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ldst_store_slot.sv
// One store slot: reads VLEN source words, drives VLEN memory write lanes.
module ldst_store_slot #(
  parameter int AW   = 11,
  parameter int DW   = 32,
  parameter int VLEN = 8
) (
  input  logic               en,
  input  logic               vec,
  input  logic [AW-1:0]      src,
  input  logic [DW-1:0]      aptr_data,
  output logic [VLEN*AW-1:0] src_raddr,
  input  logic [VLEN*DW-1:0] src_rdata,
  output logic [VLEN-1:0]    mem_we,
  output logic [VLEN*AW-1:0] mem_waddr,
  output logic [VLEN*DW-1:0] mem_wdata
);
  logic [AW-1:0] base;
  logic          unused_ptr_hi;

  assign base          = aptr_data[AW-1:0];
  assign unused_ptr_hi = &{1'b0, aptr_data};

  for (genvar j = 0; j < VLEN; j++) begin : g_lane
    assign src_raddr[j*AW +: AW] = src + AW'(j);
    assign mem_waddr[j*AW +: AW] = base + AW'(j);
    assign mem_wdata[j*DW +: DW] = src_rdata[j*DW +: DW];
    if (j == 0) begin : g_l0
      assign mem_we[0] = en;
    end else begin : g_ln
      assign mem_we[j] = en & vec;
    end
  end
endmodule

// File: rtl/ldst_engine.sv
module ldst_engine #(
  parameter int N_LOAD    = 2,
  parameter int N_STORE   = 2,
  parameter int VLEN      = 8,
  parameter int AW        = 11,
  parameter int DW        = 32,
  parameter int SCR_DEPTH = 256,
  parameter int MEM_DEPTH = 512
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_LOAD-1:0]     ld_en,
  input  logic [2*N_LOAD-1:0]   ld_op,
  input  logic [AW*N_LOAD-1:0]  ld_dst,
  input  logic [AW*N_LOAD-1:0]  ld_src,
  input  logic [DW*N_LOAD-1:0]  ld_imm,
  input  logic [N_STORE-1:0]    st_en,
  input  logic [N_STORE-1:0]    st_vec,
  input  logic [AW*N_STORE-1:0] st_aptr,
  input  logic [AW*N_STORE-1:0] st_src,
  input  logic [AW-1:0]         obs_addr,
  output logic [DW-1:0]         obs_data
);
  // Scratch read port map: load pointers, store pointers, store data, observe.
  localparam int SP_STA   = N_LOAD;
  localparam int SP_STD   = N_LOAD + N_STORE;
  localparam int SP_OBS   = SP_STD + N_STORE * VLEN;
  localparam int SCR_NRD  = SP_OBS + 1;
  localparam int SCR_NWR  = N_LOAD * VLEN;
  localparam int MEM_NRD  = N_LOAD * VLEN;
  localparam int MEM_NWR  = N_STORE * VLEN;

  logic [SCR_NRD*AW-1:0] scr_raddr;
  logic [SCR_NRD*DW-1:0] scr_rdata;
  logic [SCR_NWR-1:0]    scr_we;
  logic [SCR_NWR*AW-1:0] scr_waddr;
  logic [SCR_NWR*DW-1:0] scr_wdata;
  logic [MEM_NRD*AW-1:0] mem_raddr;
  logic [MEM_NRD*DW-1:0] mem_rdata;
  logic [MEM_NWR-1:0]    mem_we;
  logic [MEM_NWR*AW-1:0] mem_waddr;
  logic [MEM_NWR*DW-1:0] mem_wdata;
  logic [DW-1:0]         obs_q;

  ldst_regfile #(
    .DEPTH(SCR_DEPTH), .AW(AW), .DW(DW), .NRD(SCR_NRD), .NWR(SCR_NWR)
  ) u_scratch (
    .clk(clk), .rst(rst),
    .rd_addr(scr_raddr), .rd_data(scr_rdata),
    .wr_en(scr_we), .wr_addr(scr_waddr), .wr_data(scr_wdata)
  );

  ldst_regfile #(
    .DEPTH(MEM_DEPTH), .AW(AW), .DW(DW), .NRD(MEM_NRD), .NWR(MEM_NWR)
  ) u_mem (
    .clk(clk), .rst(rst),
    .rd_addr(mem_raddr), .rd_data(mem_rdata),
    .wr_en(mem_we), .wr_addr(mem_waddr), .wr_data(mem_wdata)
  );

  for (genvar l = 0; l < N_LOAD; l++) begin : g_ld
    ldst_load_slot #(.AW(AW), .DW(DW), .VLEN(VLEN)) u_slot (
      .en       (ld_en[l]),
      .op       (ld_op[l*2 +: 2]),
      .dst      (ld_dst[l*AW +: AW]),
      .src      (ld_src[l*AW +: AW]),
      .imm      (ld_imm[l*DW +: DW]),
      .scr_raddr(scr_raddr[l*AW +: AW]),
      .scr_rdata(scr_rdata[l*DW +: DW]),
      .mem_raddr(mem_raddr[l*VLEN*AW +: VLEN*AW]),
      .mem_rdata(mem_rdata[l*VLEN*DW +: VLEN*DW]),
      .wr_en    (scr_we[l*VLEN +: VLEN]),
      .wr_addr  (scr_waddr[l*VLEN*AW +: VLEN*AW]),
      .wr_data  (scr_wdata[l*VLEN*DW +: VLEN*DW])
    );
  end

  for (genvar s = 0; s < N_STORE; s++) begin : g_st
    assign scr_raddr[(SP_STA+s)*AW +: AW] = st_aptr[s*AW +: AW];
    ldst_store_slot #(.AW(AW), .DW(DW), .VLEN(VLEN)) u_slot (
      .en       (st_en[s]),
      .vec      (st_vec[s]),
      .src      (st_src[s*AW +: AW]),
      .aptr_data(scr_rdata[(SP_STA+s)*DW +: DW]),
      .src_raddr(scr_raddr[(SP_STD+s*VLEN)*AW +: VLEN*AW]),
      .src_rdata(scr_rdata[(SP_STD+s*VLEN)*DW +: VLEN*DW]),
      .mem_we   (mem_we[s*VLEN +: VLEN]),
      .mem_waddr(mem_waddr[s*VLEN*AW +: VLEN*AW]),
      .mem_wdata(mem_wdata[s*VLEN*DW +: VLEN*DW])
    );
  end

  assign scr_raddr[SP_OBS*AW +: AW] = obs_addr;

  always_ff @(posedge clk) begin
    if (rst) obs_q <= '0;
    else     obs_q <= scr_rdata[SP_OBS*DW +: DW];
  end

  assign obs_data = obs_q;
endmodule

// File: rtl/ldst_engine_chk.sv
module ldst_engine_chk #(
  parameter int AW = 11,
  parameter int DW = 32,
  parameter int NL = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [NL-1:0]   ld_en,
  input logic [2*NL-1:0] ld_op,
  input logic [AW*NL-1:0] ld_dst,
  input logic [DW*NL-1:0] ld_imm,
  input logic [AW-1:0]   obs_addr,
  input logic [DW-1:0]   obs_data
);
  AST_RESET_CLEARS_OBS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> obs_data == '0); // R1

  AST_IDLE_HOLDS_SCRATCH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) && $past(ld_en == '0, 2) &&
     $past(obs_addr, 1) == $past(obs_addr, 2))
    |-> obs_data == $past(obs_data, 1)); // R10

  AST_LAST_SLOT_WINS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) &&
     $past(ld_en[NL-1] && ld_op[2*NL-1 -: 2] == 2'b00, 2) &&
     $past(obs_addr, 1) == $past(ld_dst[AW*NL-1 -: AW], 2))
    |-> obs_data == $past(ld_imm[DW*NL-1 -: DW], 2)); // R9

  AST_CONST_COMMITS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) &&
     $past(ld_en == NL'(1) && ld_op[1:0] == 2'b00, 2) &&
     $past(obs_addr, 1) == $past(ld_dst[AW-1:0], 2))
    |-> obs_data == $past(ld_imm[DW-1:0], 2)); // R2
endmodule

bind ldst_engine ldst_engine_chk #(.AW(AW), .DW(DW), .NL(N_LOAD)) chk_i (
  .clk(clk), .rst(rst), .ld_en(ld_en), .ld_op(ld_op), .ld_dst(ld_dst),
  .ld_imm(ld_imm), .obs_addr(obs_addr), .obs_data(obs_data)
);

// File: tb/ldst_engine_tb_top.sv
module ldst_engine_tb_top;
  localparam int NL = 2;
  localparam int NS = 2;
  localparam int AW = 11;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NL-1:0]    ld_en = '0;
  logic [2*NL-1:0]  ld_op = '0;
  logic [AW*NL-1:0] ld_dst = '0;
  logic [AW*NL-1:0] ld_src = '0;
  logic [DW*NL-1:0] ld_imm = '0;
  logic [NS-1:0]    st_en = '0;
  logic [NS-1:0]    st_vec = '0;
  logic [AW*NS-1:0] st_aptr = '0;
  logic [AW*NS-1:0] st_src = '0;
  logic [AW-1:0]    obs_addr = '0;
  logic [DW-1:0]    obs_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  ldst_engine dut_i (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_op(ld_op), .ld_dst(ld_dst),
    .ld_src(ld_src), .ld_imm(ld_imm), .st_en(st_en), .st_vec(st_vec),
    .st_aptr(st_aptr), .st_src(st_src), .obs_addr(obs_addr), .obs_data(obs_data)
  );

  localparam logic [1:0] OP_IMM = 2'b00, OP_WORD = 2'b01,
                         OP_BLOCK = 2'b10, OP_GATHER = 2'b11;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  task automatic set_ld(input int s, input logic [1:0] op, input int dst,
                        input int src, input logic [31:0] imm, input bit en = 1'b1);
    ld_en[s]            = en;
    ld_op[s*2 +: 2]     = op;
    ld_dst[s*AW +: AW]  = AW'(dst);
    ld_src[s*AW +: AW]  = AW'(src);
    ld_imm[s*DW +: DW]  = imm;
  endtask

  task automatic set_st(input int s, input bit vec, input int aptr, input int src,
                        input bit en = 1'b1);
    st_en[s]             = en;
    st_vec[s]            = vec;
    st_aptr[s*AW +: AW]  = AW'(aptr);
    st_src[s*AW +: AW]   = AW'(src);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    ld_en = '0; ld_op = '0; ld_dst = '0; ld_src = '0; ld_imm = '0;
    st_en = '0; st_vec = '0; st_aptr = '0; st_src = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    obs_addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    v = obs_data;
  endtask

  // Read mem[addr] back through scratch words 200 and 201.
  task automatic peek(input int addr, output logic [31:0] v);
    set_ld(0, OP_IMM, 200, 0, 32'(addr));
    step();
    set_ld(0, OP_WORD, 201, 200, '0);
    step();
    rd(201, v);
  endtask

  task automatic t_reset();
    chk("R1 obs_data after reset", obs_data, 32'h0);
  endtask

  task automatic t_const();
    logic [31:0] v;
    set_ld(0, OP_IMM, 10, 0, 32'hDEADBEEF);
    set_ld(1, OP_IMM, 11, 0, 32'h0BADF00D);
    step();
    rd(10, v); chk("R2 imm slot0", v, 32'hDEADBEEF);
    rd(11, v); chk("R2 imm slot1", v, 32'h0BADF00D);
  endtask

  task automatic t_word();
    logic [31:0] v;
    set_ld(0, OP_IMM, 20, 0, 32'd100);
    set_ld(1, OP_IMM, 21, 0, 32'h12345678);
    step();
    set_st(0, 1'b0, 20, 21);
    step();
    set_ld(0, OP_WORD, 30, 20, '0);
    step();
    rd(30, v); chk("R3 R6 word store then word load", v, 32'h12345678);
  endtask

  task automatic t_block();
    logic [31:0] v;
    for (int j = 0; j < 8; j += 2) begin
      set_ld(0, OP_IMM, 40 + j, 0, 32'hA0000000 + 32'(j));
      set_ld(1, OP_IMM, 41 + j, 0, 32'hA0000001 + 32'(j));
      step();
    end
    set_ld(0, OP_IMM, 50, 0, 32'd200);
    step();
    set_st(0, 1'b1, 50, 40);
    step();
    set_ld(0, OP_BLOCK, 60, 50, '0);
    step();
    for (int j = 0; j < 8; j++) begin
      rd(60 + j, v); chk("R4 block load lane", v, 32'hA0000000 + 32'(j));
    end
    peek(203, v); chk("R7 block store word 3", v, 32'hA0000003);
  endtask

  task automatic t_gather();
    logic [31:0] v;
    for (int j = 0; j < 8; j += 2) begin
      set_ld(0, OP_IMM, 70 + j, 0, 32'(200 + 7 - j));
      set_ld(1, OP_IMM, 71 + j, 0, 32'(200 + 6 - j));
      step();
    end
    set_ld(0, OP_IMM, 80, 0, 32'h11110000);
    set_ld(1, OP_IMM, 83, 0, 32'h22220000);
    step();
    set_ld(0, OP_GATHER, 80, 70, 32'd3);
    step();
    rd(83, v); chk("R5 gather lane 3", v, 32'hA0000004);
    rd(80, v); chk("R5 gather leaves lane 0", v, 32'h11110000);
    set_ld(0, OP_GATHER, 80, 70, 32'd8);
    step();
    rd(80, v); chk("R5 gather lane from imm[2:0]", v, 32'hA0000007);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    set_ld(0, OP_IMM, 22, 0, 32'hCAFE0001);
    step();
    set_ld(0, OP_IMM, 20, 0, 32'd101);
    set_ld(1, OP_WORD, 92, 20, '0);
    set_st(0, 1'b0, 20, 22);
    step();
    rd(92, v); chk("R8 load sees old pointer and old mem", v, 32'h12345678);
    peek(100, v); chk("R8 store uses old pointer", v, 32'hCAFE0001);
    rd(20, v); chk("R8 pointer updated after cycle", v, 32'd101);
    set_ld(0, OP_IMM, 22, 0, 32'h99990000);
    set_st(0, 1'b0, 20, 22);
    step();
    peek(101, v); chk("R8 store sees old data word", v, 32'hCAFE0001);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    set_ld(0, OP_IMM, 95, 0, 32'd1);
    set_ld(1, OP_IMM, 95, 0, 32'd2);
    step();
    rd(95, v); chk("R9 scratch clash slot1 wins", v, 32'd2);
    set_ld(0, OP_BLOCK, 96, 50, '0);
    set_ld(1, OP_IMM, 98, 0, 32'h00007777);
    step();
    rd(98, v); chk("R9 imm over block lane", v, 32'h00007777);
    rd(97, v); chk("R9 other block lane intact", v, 32'hA0000001);
    set_st(0, 1'b0, 20, 21);
    set_st(1, 1'b0, 20, 22);
    step();
    peek(101, v); chk("R9 memory clash slot1 wins", v, 32'h99990000);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    set_ld(0, OP_IMM, 10, 0, 32'h00000777, 1'b0);
    set_ld(1, OP_BLOCK, 10, 50, '0, 1'b0);
    set_st(0, 1'b0, 20, 21, 1'b0);
    set_st(1, 1'b1, 20, 40, 1'b0);
    step();
    rd(10, v); chk("R10 disabled loads leave scratch", v, 32'hDEADBEEF);
    peek(101, v); chk("R10 disabled stores leave memory", v, 32'h99990000);
    set_st(0, 1'b1, 50, 40);
    step();
    rd(40, v); chk("R10 store leaves scratch source", v, 32'hA0000000);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    set_ld(0, OP_IMM, 51, 0, 32'd509);
    step();
    set_st(0, 1'b1, 51, 40);
    step();
    peek(2, v);    chk("R11 block store wraps memory", v, 32'hA0000005);
    peek(1533, v); chk("R11 memory index modulo depth", v, 32'hA0000000);
    set_ld(0, OP_BLOCK, 254, 51, '0);
    step();
    rd(1, v);   chk("R11 block load wraps scratch", v, 32'hA0000003);
    rd(257, v); chk("R11 scratch index modulo depth", v, 32'hA0000003);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_const();
    t_word();
    t_block();
    t_gather();
    t_same_cycle();
    t_priority();
    t_disabled();
    t_wrap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired before all scenarios finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule